// File: doc/BRIEF.md
# Dual-Bank Mixed-Trigger Interrupt Controller

The block gathers sixty-four interrupt request lines into two banks of thirty-two bits and reduces them to a single interrupt line for one processor. Each input is either edge-latched or level-sensitive, and this choice is fixed by a parameter. An edge-latched source records a pending event on the rising edge of its synchronized input. The event stays pending until software clears it. A level-sensitive source never records an event. It requests service only while its input is high.

Software reaches the banks through a plain 32-bit register port with a valid strobe and a write flag. Each bank provides three readable views: its latched events, its mask and its raw input levels. It also provides a write-one-to-clear register for events. Clearing has no effect on level-sensitive bits. Input numbering is reversed across the banks: lines 0 to 31 belong to bank 1 and lines 32 to 63 belong to bank 0. The processor line is registered, so it follows the mask, the events and the levels one clock later.

Top module: `mixed_irq_ctrl`

## Requirements
- R1: Input n is held in bank 1 − (n >> 5) at bit n & 31. Lines 0–31 appear in bank 1 and lines 32–63 appear in bank 0.
- R2: The bank index is ((addr − 0x10) >> 4), computed on the 12-bit address with wrap-around. Bank 0 sits at 0x10 and bank 1 sits at 0x20. An access whose index is 2 or more writes nothing and reads zero; this includes addresses below 0x10.
- R3: The low address nibble selects the register: 0x0 is events (read only), 0x4 is mask (read/write), 0x8 is event clear (write only, reads zero) and 0xC is raw levels (read only). Any other nibble reads zero and ignores writes. Read data is zero unless valid is high and write is low.
- R4: An edge-latched source's event bit is set two clocks after its input rises. The bit stays set after the input falls.
- R5: The level-sensitive sources are bits 20–28 of bank 1 (constant 0x1FF00000); bank 0 has none. These bits never set an event. Each one requests service while its raw-level bit is high.
- R6: Writing the clear register clears each event bit written as 1. Ones written at level-sensitive positions are discarded.
- R7: When a rising edge and a clear of the same bit land in the same clock, the bit stays set.
- R8: A bank is pending when (events | (levels & level_sensitive)) & mask is nonzero. cpu_irq_o is the OR of both banks, registered one clock after the state that produces it.
- R9: After reset, events, mask and levels read zero and cpu_irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 64 | Interrupt request lines, asynchronous |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| cpu_irq_o | output | 1 | Interrupt request to the processor |

## Verification
Two functions can fall in the same cycle: the latch of a newly detected rising edge and a software write to the clear register for the same bit. The bench provokes this by raising the input and then starting the clear write so that it is sampled at the exact edge where the event bit loads. It judges the result by reading the bit back and expecting it still set. A randomized phase mixes input toggles with reads and writes across every offset, including aliased and out-of-range addresses. In that phase a behavioural model compares the interrupt line and the read data on every clock, which covers mask updates that coincide with level changes and event latches.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned DEC_ADDR_W  = 12;
  localparam int unsigned BANK_BASE   = 16;
  localparam int unsigned BANK_STEP_LG = 4;
  localparam logic [63:0] DEFAULT_LVL_SRC = 64'h1FF0_0000_0000_0000;

  typedef enum logic [3:0] {
    SEL_EVENT = 4'h0,
    SEL_MASK  = 4'h4,
    SEL_CLEAR = 4'h8,
    SEL_LEVEL = 4'hC
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] LVL_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         mask_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] events_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] levels_o,
  output logic         pend_o
);
  logic [W-1:0] events_q, mask_q, levels_q;
  logic [W-1:0] set_vec, clr_vec, events_d;

  // levels_q holds the previous synchronized sample, so it doubles as edge history
  assign set_vec  = src_i & ~levels_q & ~LVL_MASK;
  assign clr_vec  = clr_we_i ? (wdata_i & ~LVL_MASK) : '0;
  assign events_d = (events_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      events_q <= '0;
      mask_q   <= '0;
      levels_q <= '0;
    end else begin
      events_q <= events_d;
      levels_q <= src_i;
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign events_o = events_q;
  assign mask_o   = mask_q;
  assign levels_o = levels_q;
  assign pend_o   = |((events_q | (levels_q & LVL_MASK)) & mask_q);

  p_edge_latch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_vec) |=> ((events_q & $past(set_vec)) == $past(set_vec)));

  p_event_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> (($past(events_q) & ~events_q) == '0));

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((events_q & $past(wdata_i & ~LVL_MASK) & ~$past(set_vec)) == '0));

  p_mask_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q));
endmodule

// File: rtl/irq_regif.sv
module irq_regif
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned W         = 32
) (
  input  logic                          valid_i,
  input  logic                          write_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [NUM_BANKS-1:0][W-1:0]   events_i,
  input  logic [NUM_BANKS-1:0][W-1:0]   mask_i,
  input  logic [NUM_BANKS-1:0][W-1:0]   levels_i,
  output logic [NUM_BANKS-1:0]          mask_we_o,
  output logic [NUM_BANKS-1:0]          clr_we_o,
  output logic [W-1:0]                  rdata_o
);
  localparam int unsigned IDX_W = ADDR_W - BANK_STEP_LG;

  logic [ADDR_W-1:0] rel;
  logic [IDX_W-1:0]  idx;
  reg_sel_e          sel;

  assign rel = addr_i - ADDR_W'(BANK_BASE);
  assign idx = rel[ADDR_W-1:BANK_STEP_LG];
  assign sel = reg_sel_e'(addr_i[BANK_STEP_LG-1:0]);

  always_comb begin
    mask_we_o = '0;
    clr_we_o  = '0;
    rdata_o   = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (valid_i && idx == IDX_W'(b)) begin
        if (write_i) begin
          case (sel)
            SEL_MASK:  mask_we_o[b] = 1'b1;
            SEL_CLEAR: clr_we_o[b]  = 1'b1;
            default: ;
          endcase
        end else begin
          case (sel)
            SEL_EVENT: rdata_o = events_i[b];
            SEL_MASK:  rdata_o = mask_i[b];
            SEL_LEVEL: rdata_o = levels_i[b];
            default:   rdata_o = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/mixed_irq_ctrl.sv
module mixed_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEC_ADDR_W,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned NUM_BANKS = 2,
  parameter logic [NUM_BANKS*BANK_W-1:0] LVL_SRC = DEFAULT_LVL_SRC
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_BANKS*BANK_W-1:0] irq_i,
  input  logic                        bus_valid_i,
  input  logic                        bus_write_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [BANK_W-1:0]           bus_wdata_i,
  output logic [BANK_W-1:0]           bus_rdata_o,
  output logic                        cpu_irq_o
);
  localparam int unsigned SRC_W = NUM_BANKS * BANK_W;
  localparam logic [ADDR_W-1:0] DEC_LO = ADDR_W'(BANK_BASE);
  localparam logic [ADDR_W-1:0] DEC_HI = ADDR_W'(BANK_BASE + NUM_BANKS * (2 ** BANK_STEP_LG));

  logic [SRC_W-1:0]                 src_sync;
  logic [NUM_BANKS-1:0][BANK_W-1:0] ev_w, mask_w, lvl_w;
  logic [NUM_BANKS-1:0]             mask_we, clr_we, pend;
  logic                             irq_q;

  irq_sync #(.W(SRC_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(irq_i),
    .sync_o (src_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    // numbering is reversed: the highest input block feeds bank 0
    irq_bank #(
      .W       (BANK_W),
      .LVL_MASK(LVL_SRC[b*BANK_W +: BANK_W])
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (src_sync[(NUM_BANKS-1-b)*BANK_W +: BANK_W]),
      .mask_we_i(mask_we[b]),
      .clr_we_i (clr_we[b]),
      .wdata_i  (bus_wdata_i),
      .events_o (ev_w[b]),
      .mask_o   (mask_w[b]),
      .levels_o (lvl_w[b]),
      .pend_o   (pend[b])
    );
  end

  irq_regif #(
    .ADDR_W   (ADDR_W),
    .NUM_BANKS(NUM_BANKS),
    .W        (BANK_W)
  ) u_regif (
    .valid_i  (bus_valid_i),
    .write_i  (bus_write_i),
    .addr_i   (bus_addr_i),
    .events_i (ev_w),
    .mask_i   (mask_w),
    .levels_i (lvl_w),
    .mask_we_o(mask_we),
    .clr_we_o (clr_we),
    .rdata_o  (bus_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |pend;
  end

  assign cpu_irq_o = irq_q;

  p_irq_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_irq_o == $past(|pend));

  p_single_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mask_we, clr_we}));

  p_out_of_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i < DEC_LO || bus_addr_i >= DEC_HI) |->
      (mask_we == '0 && clr_we == '0 && bus_rdata_o == '0));
endmodule

// File: tb/mixed_irq_ctrl_test.sv
module mixed_irq_ctrl_test;
  localparam logic [31:0] LVL_B1 = 32'h1FF0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq = '0;
  logic        valid = 1'b0, write = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         cpu_irq;

  int    checks = 0, errors = 0;
  string cur_req = "R9";
  logic [31:0] lfsr = 32'hACE1_2357;

  mixed_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .bus_valid_i(valid), .bus_write_i(write), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cpu_irq_o(cpu_irq)
  );

  always #4 clk = ~clk;

  // behavioural reference model
  logic [63:0] m_s1, m_s2;
  logic [31:0] m_ev [2];
  logic [31:0] m_mask [2];
  logic [31:0] m_lvl [2];
  logic        m_irq;

  function automatic int bank_of(logic [11:0] a);
    if (a < 12'h010) return 99;
    return (int'(a) - 16) / 16;
  endfunction

  function automatic logic [31:0] lvl_src(int b);
    return (b == 1) ? LVL_B1 : 32'h0;
  endfunction

  function automatic logic [31:0] model_read();
    int b;
    if (!valid || write) return 32'h0;
    b = bank_of(addr);
    if (b > 1) return 32'h0;
    case (addr[3:0])
      4'h0: return m_ev[b];
      4'h4: return m_mask[b];
      4'hC: return m_lvl[b];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_irq = 1'b0;
      for (int b = 0; b < 2; b++) begin m_ev[b] = '0; m_mask[b] = '0; m_lvl[b] = '0; end
    end else begin
      logic        pend;
      logic [31:0] n_ev [2];
      logic [31:0] n_mask [2];
      logic [31:0] n_lvl [2];
      int          wb;
      pend = 1'b0;
      wb = (valid && write) ? bank_of(addr) : 99;
      for (int b = 0; b < 2; b++) begin
        if (((m_ev[b] | (m_lvl[b] & lvl_src(b))) & m_mask[b]) != 0) pend = 1'b1;
        n_ev[b] = m_ev[b];
        n_mask[b] = m_mask[b];
        for (int i = 0; i < 32; i++) begin
          int  n;
          logic lv;
          n = (1 - b) * 32 + i;
          lv = lvl_src(b)[i];
          n_lvl[b][i] = m_s2[n];
          if (wb == b && addr[3:0] == 4'h8 && wdata[i] && !lv) n_ev[b][i] = 1'b0;
          if (m_s2[n] && !m_lvl[b][i] && !lv) n_ev[b][i] = 1'b1;
        end
        if (wb == b && addr[3:0] == 4'h4) n_mask[b] = wdata;
      end
      m_irq = pend;
      m_s2 = m_s1;
      m_s1 = irq;
      for (int b = 0; b < 2; b++) begin m_ev[b] = n_ev[b]; m_mask[b] = n_mask[b]; m_lvl[b] = n_lvl[b]; end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk(cur_req, "cpu_irq vs model", {31'h0, cpu_irq}, {31'h0, m_irq});
      chk(cur_req, "rdata vs model", rdata, model_read());
    end
  end

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk); valid = 1'b0; write = 1'b0;
  endtask

  task automatic bus_rd(logic [11:0] a, logic [31:0] exp, string req);
    @(negedge clk); valid = 1'b1; write = 1'b0; addr = a;
    #2; chk(req, "read", rdata, exp);
    @(negedge clk); valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(logic exp, string req);
    #2; chk(req, "cpu_irq", {31'h0, cpu_irq}, {31'h0, exp});
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R9 reset state
    chk_irq(1'b0, "R9");
    bus_rd(12'h010, 32'h0, "R9"); bus_rd(12'h014, 32'h0, "R9"); bus_rd(12'h01C, 32'h0, "R9");
    bus_rd(12'h020, 32'h0, "R9"); bus_rd(12'h024, 32'h0, "R9"); bus_rd(12'h02C, 32'h0, "R9");

    // R1 bank reversal, R4 edge latch
    cur_req = "R1";
    @(negedge clk); irq[0] = 1'b1; irq[63] = 1'b1;
    idle(4);
    bus_rd(12'h020, 32'h0000_0001, "R1");
    bus_rd(12'h010, 32'h8000_0000, "R1");
    bus_rd(12'h02C, 32'h0000_0001, "R1");
    bus_rd(12'h01C, 32'h8000_0000, "R1");
    cur_req = "R4";
    @(negedge clk); irq[0] = 1'b0; irq[63] = 1'b0;
    idle(4);
    bus_rd(12'h020, 32'h0000_0001, "R4");
    bus_rd(12'h02C, 32'h0000_0000, "R4");
    chk_irq(1'b0, "R8");

    // R8 mask gating
    cur_req = "R8";
    bus_wr(12'h024, 32'h0000_0001); idle(2); chk_irq(1'b1, "R8");
    bus_wr(12'h024, 32'h0000_0000); idle(2); chk_irq(1'b0, "R8");
    bus_wr(12'h014, 32'h8000_0000); idle(2); chk_irq(1'b1, "R8");

    // R6 write-one clear
    cur_req = "R6";
    bus_wr(12'h018, 32'h8000_0000); idle(2); chk_irq(1'b0, "R6");
    bus_rd(12'h010, 32'h0, "R6");
    bus_wr(12'h028, 32'hFFFF_FFFF);
    bus_rd(12'h020, 32'h0, "R6");
    bus_wr(12'h014, 32'h0);

    // R5 level-sensitive source
    cur_req = "R5";
    bus_wr(12'h024, 32'h0010_0000);
    @(negedge clk); irq[20] = 1'b1;
    idle(4);
    bus_rd(12'h020, 32'h0, "R5");
    bus_rd(12'h02C, 32'h0010_0000, "R5");
    chk_irq(1'b1, "R5");
    bus_wr(12'h028, 32'hFFFF_FFFF); idle(2); chk_irq(1'b1, "R6");
    @(negedge clk); irq[20] = 1'b0;
    idle(4); chk_irq(1'b0, "R5");
    bus_wr(12'h024, 32'h0);

    // R7 edge and clear in the same clock
    cur_req = "R7";
    @(negedge clk); irq[5] = 1'b1;
    @(negedge clk);
    bus_wr(12'h028, 32'h0000_0020);
    idle(2);
    bus_rd(12'h020, 32'h0000_0020, "R7");
    @(negedge clk); irq[5] = 1'b0;
    bus_wr(12'h028, 32'h0000_0020);
    bus_rd(12'h020, 32'h0, "R7");

    // R2 out-of-range and wrap-around decode
    cur_req = "R2";
    bus_wr(12'h014, 32'h0000_00F0);
    bus_wr(12'h034, 32'hFFFF_FFFF);
    bus_wr(12'h004, 32'hFFFF_FFFF);
    bus_wr(12'hFF4, 32'hFFFF_FFFF);
    bus_rd(12'h014, 32'h0000_00F0, "R2");
    bus_rd(12'h024, 32'h0, "R2");
    bus_rd(12'h034, 32'h0, "R2");
    bus_rd(12'h004, 32'h0, "R2");

    // R3 offsets
    cur_req = "R3";
    bus_wr(12'h02C, 32'hFFFF_FFFF);
    bus_wr(12'h021, 32'hFFFF_FFFF);
    bus_wr(12'h020, 32'hFFFF_FFFF);
    bus_rd(12'h02C, 32'h0, "R3");
    bus_rd(12'h024, 32'h0, "R3");
    bus_rd(12'h020, 32'h0, "R3");
    bus_rd(12'h018, 32'h0, "R3");
    bus_rd(12'h016, 32'h0, "R3");
    bus_wr(12'h014, 32'h0);

    // mixed random traffic, judged per clock by the model
    cur_req = "R8";
    for (int k = 0; k < 2000; k++) begin
      logic [11:0] pick;
      @(negedge clk);
      step_lfsr();
      if (lfsr[2:0] == 3'd0) irq[lfsr[8:3]] = ~irq[lfsr[8:3]];
      if (lfsr[12:10] == 3'd1) irq[20 + int'(lfsr[15:13])] = ~irq[20 + int'(lfsr[15:13])];
      pick = {4'h0, lfsr[20:19] == 2'b11 ? 4'h3 : {2'b0, lfsr[20:19]}, lfsr[18:17], 2'b00};
      if (lfsr[22:21] == 2'b00) pick = pick | 12'h001;
      valid = lfsr[23];
      write = lfsr[24];
      addr  = pick;
      step_lfsr();
      wdata = lfsr;
    end
    @(negedge clk); valid = 1'b0; write = 1'b0;
    idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule